// File: doc/BRIEF.md
# Packed Unsigned Multiply-High Unit

This unit is a SIMD datapath that views each operand vector as an array of 16-bit unsigned lanes. For every lane it forms the full 32-bit unsigned product of the two sources and keeps only the upper 16 bits. Each result is written back into the lane position it came from. There are no status flags and no numeric exceptions.

A mode input picks how wide the operation is and what happens to destination bits above that width. Two modes model narrower registers and keep the previous destination contents above their width. A third mode zeroes everything above 128 bits. The widest mode covers all 256 bits. One encoding is illegal: the zeroing 128-bit mode combined with the length bit set. That request yields an undefined-operation pulse instead of a result.

The datapath has two register stages. Stage one registers the lane multiplies. Stage two selects lanes per mode, merges them with the old destination and registers the result. Instruction decode, register files and memory operands sit outside the block.

Top module: `pmh_unit`

## Requirements
- R1: Lane i occupies bits [16i+15:16i] of both sources. Its result is bits [31:16] of the 32-bit unsigned product of the two lanes, placed back in bits [16i+15:16i]. Results never move between lanes.
- R2: With `in_mode` = 0 (64-bit form), lanes 0..3 carry products and bits [255:64] equal `old_dst` bits [255:64].
- R3: With `in_mode` = 1 (128-bit merging form), lanes 0..7 carry products and bits [255:128] equal `old_dst` bits [255:128].
- R4: With `in_mode` = 2 (128-bit zeroing form) and `in_len_bit` = 0, lanes 0..7 carry products and bits [255:128] are zero.
- R5: With `in_mode` = 3 (256-bit form), all 16 lanes carry products.
- R6: A legal request with `in_valid` high produces `out_valid` high exactly two cycles later. Requests may arrive on consecutive cycles, and each one produces its own result in order.
- R7: `in_mode` = 2 with `in_len_bit` = 1 is illegal. Two cycles later, `out_undef` pulses high for one cycle and `out_valid` stays low for that request.
- R8: `in_len_bit` has no effect in modes 0, 1 and 3.
- R9: While reset is held, and in the cycle after it is released, `out_valid` and `out_undef` are low.
- R10: The corner cases hold per lane: 0xFFFF*0xFFFF gives 0xFFFE, any value times 0 gives 0, and 0x0001*0xFFFF gives 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_mode | input | 2 | Operating form: 0 = 64-bit, 1 = 128-bit merging, 2 = 128-bit zeroing, 3 = 256-bit |
| in_len_bit | input | 1 | Length-select bit; 1 is illegal in mode 2 |
| src_a | input | 256 | First source vector (destination value in merging forms) |
| src_b | input | 256 | Second source vector |
| old_dst | input | 256 | Previous destination contents |
| out_valid | output | 1 | Result valid |
| out_data | output | 256 | Result vector |
| out_undef | output | 1 | Illegal-encoding pulse |

## Verification
Some properties are checked on every cycle by the embedded assertions:
- the two-cycle spacing between a legal request and its result;
- the undefined-operation pulse for the illegal encoding;
- `out_valid` and `out_undef` never being high together;
- zero bits above 128 in the zeroing form;
- preserved bits above 64 in the 64-bit form.

The lane arithmetic itself can only be shown by the bench's scenarios. It compares every lane against a reference model: over random vectors in all four forms, the three named corner products, and the length bit in the modes that ignore it. Those scenarios also cover the upper-half preservation in the 128-bit merging form and in-order back-to-back delivery.

// File: rtl/pmh_pkg.sv
package pmh_pkg;
  localparam int LANE_W = 16;
  localparam int VEC_W  = 256;

  typedef enum logic [1:0] {
    MODE_N64  = 2'd0,
    MODE_K128 = 2'd1,
    MODE_Z128 = 2'd2,
    MODE_W256 = 2'd3
  } pmh_mode_e;

  // The zeroing 128-bit form forbids the length bit.
  function automatic logic is_illegal(input pmh_mode_e m, input logic len_bit);
    return (m == MODE_Z128) && len_bit;
  endfunction
endpackage

// File: rtl/pmh_lane_mul.sv
module pmh_lane_mul #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         en,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] hi
);
  localparam int PW = 2 * W;

  function automatic logic [W-1:0] upper_half(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [PW-1:0] p;
    p = {{W{1'b0}}, x} * {{W{1'b0}}, y};
    return p[PW-1:W];
  endfunction

  always_ff @(posedge clk) begin
    if (en) hi <= upper_half(a, b);
  end
endmodule

// File: rtl/pmh_merge.sv
module pmh_merge
  import pmh_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int VEC_W  = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s1_valid,
  input  logic             s1_undef,
  input  pmh_mode_e        s1_mode,
  input  logic [VEC_W-1:0] s1_hi,
  input  logic [VEC_W-1:0] s1_old,
  output logic             out_valid,
  output logic             out_undef,
  output logic [VEC_W-1:0] out_data
);
  localparam int LANES = VEC_W / LANE_W;
  localparam int L64   = 64 / LANE_W;
  localparam int L128  = 128 / LANE_W;

  logic [VEC_W-1:0] merged;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam bit IN64  = (i < L64);
    localparam bit IN128 = (i < L128);
    logic act;
    assign act = (s1_mode == MODE_W256) || IN64 || (IN128 && s1_mode != MODE_N64);
    assign merged[i*LANE_W +: LANE_W] =
      act ? s1_hi[i*LANE_W +: LANE_W] :
      (s1_mode == MODE_Z128) ? '0 : s1_old[i*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_undef <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      out_undef <= s1_undef;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_valid) out_data <= merged;
  end

  // R4: zeroing form clears everything above 128 bits
  assert_zero_upper_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(s1_mode) == MODE_Z128) |-> (out_data[VEC_W-1:128] == '0));

  // R2: 64-bit form keeps the old destination above bit 63
  assert_keep_upper_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(s1_mode) == MODE_N64) |->
      (out_data[VEC_W-1:64] == $past(s1_old[VEC_W-1:64])));
endmodule

// File: rtl/pmh_unit.sv
module pmh_unit
  import pmh_pkg::*;
#(
  parameter int LANE_W = pmh_pkg::LANE_W,
  parameter int VEC_W  = pmh_pkg::VEC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       in_mode,
  input  logic             in_len_bit,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  input  logic [VEC_W-1:0] old_dst,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_data,
  output logic             out_undef
);
  localparam int LANES = VEC_W / LANE_W;

  pmh_mode_e        mode_in;
  logic             illegal;
  logic             accept;
  logic             s1_valid;
  logic             s1_undef;
  pmh_mode_e        s1_mode;
  logic [VEC_W-1:0] s1_old;
  logic [VEC_W-1:0] s1_hi;

  assign mode_in = pmh_mode_e'(in_mode);
  assign illegal = in_valid && is_illegal(mode_in, in_len_bit);
  assign accept  = in_valid && !illegal;

  for (genvar i = 0; i < LANES; i++) begin : g_mul
    pmh_lane_mul #(.W(LANE_W)) u_mul (
      .clk (clk),
      .en  (accept),
      .a   (src_a[i*LANE_W +: LANE_W]),
      .b   (src_b[i*LANE_W +: LANE_W]),
      .hi  (s1_hi[i*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_undef <= 1'b0;
    end else begin
      s1_valid <= accept;
      s1_undef <= illegal;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      s1_mode <= mode_in;
      s1_old  <= old_dst;
    end
  end

  pmh_merge #(.LANE_W(LANE_W), .VEC_W(VEC_W)) u_merge (
    .clk       (clk),
    .rst       (rst),
    .s1_valid  (s1_valid),
    .s1_undef  (s1_undef),
    .s1_mode   (s1_mode),
    .s1_hi     (s1_hi),
    .s1_old    (s1_old),
    .out_valid (out_valid),
    .out_undef (out_undef),
    .out_data  (out_data)
  );

  // R6: legal request returns a result two cycles later
  assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
    accept |=> ##1 out_valid);

  // R7: illegal encoding pulses the undefined flag instead of a result
  assert_undef_R7: assert property (@(posedge clk) disable iff (rst)
    illegal |=> ##1 (out_undef && !out_valid));

  // R7: flags are mutually exclusive
  assert_flags_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_undef));
endmodule

// File: tb/test_pmh_unit.sv
module test_pmh_unit;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [1:0]   in_mode;
  logic         in_len_bit;
  logic [255:0] src_a, src_b, old_dst;
  logic         out_valid;
  logic [255:0] out_data;
  logic         out_undef;

  always #4 clk = ~clk;

  pmh_unit i_pmh_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
    .in_len_bit(in_len_bit), .src_a(src_a), .src_b(src_b), .old_dst(old_dst),
    .out_valid(out_valid), .out_data(out_data), .out_undef(out_undef)
  );

  typedef struct {
    logic         undef;
    logic [255:0] data;
    int           stamp;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  int   cycle = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;

  always @(posedge clk) cycle <= cycle + 1;

  // Reference: walk the active lanes, rest is old or zero per mode.
  function automatic logic [255:0] model(input logic [1:0] m, input logic [255:0] a,
                                         input logic [255:0] b, input logic [255:0] old);
    int n;
    logic [255:0] r;
    logic [31:0] prod;
    n = (m == 2'd0) ? 4 : (m == 2'd3) ? 16 : 8;
    r = (m == 2'd2) ? 256'd0 : old;
    for (int k = 0; k < n; k++) begin
      prod = 32'(a[k*16 +: 16]) * 32'(b[k*16 +: 16]);
      r[k*16 +: 16] = 16'(prod >> 16);
    end
    return r;
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic send(input logic [1:0] m, input logic lb, input logic [255:0] a,
                      input logic [255:0] b, input logic [255:0] old, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_mode = m; in_len_bit = lb;
    src_a = a; src_b = b; old_dst = old;
    e.undef = (m == 2'd2) && lb;
    e.data  = model(m, a, b, old);
    e.stamp = cycle;
    e.tag   = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic check(input bit ok, input string tag, input logic [255:0] act,
                       input logic [255:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Monitor: pops one expected item per output event.
  always @(negedge clk) begin
    if (!rst && !done && (out_valid || out_undef)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected output", {254'd0, out_valid, out_undef}, 256'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(cycle == e.stamp + 2, {e.tag, " R6 latency"}, 256'(cycle), 256'(e.stamp + 2));
        if (e.undef)
          check(out_undef && !out_valid, {e.tag, " R7 undef"}, {254'd0, out_valid, out_undef}, 256'd1);
        else
          check(out_valid && !out_undef && out_data == e.data, e.tag, out_data, e.data);
      end
    end
  end

  initial begin
    for (int k = 0; k < 200000; k++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=<200000", cycle);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [255:0] ones, zero, onev;
    ones = '1; zero = '0;
    for (int k = 0; k < 16; k++) onev[k*16 +: 16] = 16'h0001;
    rst = 1'b1; in_valid = 1'b0; in_mode = 2'd0; in_len_bit = 1'b0;
    src_a = '0; src_b = '0; old_dst = '0;
    repeat (3) @(negedge clk);
    check(!out_valid && !out_undef, "R9 flags in reset", {254'd0, out_valid, out_undef}, 256'd0);
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid && !out_undef, "R9 flags after reset", {254'd0, out_valid, out_undef}, 256'd0);

    // R10 corner products in the full form
    send(2'd3, 1'b0, ones, ones, rnd256(), "R10 ffff*ffff");
    send(2'd3, 1'b0, rnd256(), zero, rnd256(), "R10 x*0");
    send(2'd3, 1'b0, onev, ones, rnd256(), "R10 1*ffff");
    idle(3);

    // Each form, random data, spaced and back-to-back
    for (int k = 0; k < 8; k++) begin
      send(2'd0, 1'b0, rnd256(), rnd256(), rnd256(), "R2 R1 64-bit form");
      send(2'd1, 1'b0, rnd256(), rnd256(), rnd256(), "R3 R1 128-bit merging");
      send(2'd2, 1'b0, rnd256(), rnd256(), rnd256(), "R4 R1 128-bit zeroing");
      send(2'd3, 1'b0, rnd256(), rnd256(), rnd256(), "R5 R1 256-bit form");
      idle(k % 3);
    end
    idle(3);

    // R7 illegal encoding, alone and between legal requests
    send(2'd2, 1'b1, rnd256(), rnd256(), rnd256(), "R7 illegal");
    idle(3);
    send(2'd3, 1'b0, rnd256(), rnd256(), rnd256(), "R6 before illegal");
    send(2'd2, 1'b1, ones, ones, ones, "R7 illegal back-to-back");
    send(2'd1, 1'b0, rnd256(), rnd256(), rnd256(), "R6 after illegal");
    idle(3);

    // R8 length bit ignored outside the zeroing form
    send(2'd0, 1'b1, rnd256(), rnd256(), rnd256(), "R8 len bit 64-bit");
    send(2'd1, 1'b1, rnd256(), rnd256(), rnd256(), "R8 len bit 128-bit merging");
    send(2'd3, 1'b1, rnd256(), rnd256(), rnd256(), "R8 len bit 256-bit");
    send(2'd3, 1'b1, ones, ones, zero, "R8 R10 len bit corner");
    idle(4);

    check(exp_q.size() == 0, "R6 results outstanding", 256'(exp_q.size()), 256'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule